// File: doc/BRIEF.md
# Speculative Rename Table Rebuild Engine

This block restores the speculative register rename table after the pipeline has thrown away a run of younger entries. It does not keep snapshots at branches. It first loads the whole committed rename table into the speculative table in one cycle. It then walks forward through the reorder buffer, starting at the oldest in-flight entry and stopping just before the first discarded entry. Each surviving entry updates the table as if it were retiring. The result is the mapping that was in force just before the first discarded entry was renamed.

The table has one slot for each architectural register and one extra slot for the condition-flags mapping. A surviving entry can write a register slot, the flags slot, both, or neither. The flags slot is rebuilt in the same walk from the tags the entries recorded, so a flag tag comes back even if the register that carried it has since been released.

While the rebuild runs, `busy` is high and the rename stage must stall. Rename writes presented during that time are dropped. A single-cycle `done` marks the point where the rebuilt table is valid. From that cycle on, rename writes are applied on top of the rebuilt table.

The engine is a four-state machine:
- `ST_IDLE` goes to `ST_COPY` when `start` is seen.
- `ST_COPY` loads the committed table and always goes to `ST_WALK`.
- `ST_WALK` applies one entry per cycle while the cursor differs from the stop index. It goes to `ST_DONE` when the two are equal.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `rat_rebuild`

## Requirements
- R1: Reset values:
  - Each register slot i holds tag i, and the flags slot (slot 16) holds tag 16.
  - `busy` and `done` are low.
  - `spec_map` packs slot i at bits [6*i+5 : 6*i].
- R2: `start` seen in `ST_IDLE` raises `busy` from the next cycle. `busy` stays high until `done`. A `start` seen while the engine is busy or done is ignored.
- R3: The cycle after `start` is accepted, the whole table, including the flags slot, is overwritten with `cmt_map`.
- R4: Entries are replayed in program order, from `start_idx` up to but not including `stop_idx`. The index wraps modulo 16. When two entries write the same slot, the later one wins.
- R5: An entry with `rob_reg_we` low leaves its register slot unchanged, and one with `rob_flag_we` low leaves the flags slot unchanged. An entry with both low changes nothing.
- R6: An entry with `rob_flag_we` high sets the flags slot to `rob_flag_tag` during the walk.
- R7: With N surviving entries, `busy` is high for exactly N+2 cycles. `done` is then high for exactly one cycle, with `busy` low.
- R8: During the k-th replay cycle (k = 0..N-1), `rob_rd_idx` equals (`start_idx` + k) mod 16.
- R9: Rename writes (`ren_reg_we` to slot `ren_reg_arch`, `ren_flag_we` to the flags slot) are ignored while `busy` is high. When `busy` is low they take effect at the next clock edge.
- R10: When `start_idx` equals `stop_idx`, nothing is replayed, and the result equals `cmt_map`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a rebuild |
| start_idx | input | 4 | Reorder buffer index of the oldest surviving entry |
| stop_idx | input | 4 | Reorder buffer index of the first discarded entry |
| cmt_map | input | 102 | Committed rename table, 17 slots of 6 bits |
| rob_rd_idx | output | 4 | Reorder buffer entry being read |
| rob_reg_we | input | 1 | Read entry writes a register |
| rob_reg_arch | input | 4 | Architectural destination of the read entry |
| rob_reg_tag | input | 6 | Physical tag of the read entry's register |
| rob_flag_we | input | 1 | Read entry writes the flags |
| rob_flag_tag | input | 6 | Physical tag carrying the read entry's flags |
| ren_reg_we | input | 1 | Rename stage register write |
| ren_reg_arch | input | 4 | Rename stage architectural register |
| ren_reg_tag | input | 6 | Rename stage new tag |
| ren_flag_we | input | 1 | Rename stage flags write |
| ren_flag_tag | input | 6 | Rename stage new flags tag |
| spec_map | output | 102 | Speculative rename table, 17 slots of 6 bits |
| busy | output | 1 | Rebuild in progress; rename must stall |
| done | output | 1 | One-cycle pulse: rebuilt table is valid |

## Verification
The hardest case to reach from the ports is a rename write or a second `start` arriving in the middle of a walk that wraps past the end of the reorder buffer. To get there, the stimulus sweeps every start index against survivor counts of 0, 1, 2, 7 and 15. On a fixed subset of these runs it drives rename writes and a fresh `start` with a different stop index on every busy cycle. Other runs give the entries only register writes, only flag writes, or no writes at all. Expected tables are built by replaying the same entries arithmetically in the bench.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_WALK,
        ST_DONE
    } rr_state_e;
endpackage

// File: rtl/rr_walker.sv
module rr_walker
    import rr_pkg::*;
#(
    parameter int ROB_DEPTH = 16,
    localparam int IDX_W = $clog2(ROB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] stop_idx,
    output logic [IDX_W-1:0] cursor,
    output logic             copy_en,
    output logic             step_en,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROB_DEPTH - 1);

    rr_state_e        state, state_nx;
    logic [IDX_W-1:0] stop_q;
    logic             at_stop;

    assign at_stop = (cursor == stop_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_COPY;
            ST_COPY: state_nx = ST_WALK;
            ST_WALK: if (at_stop) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cursor <= '0;
            stop_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                cursor <= start_idx;
                stop_q <= stop_idx;
            end else if (step_en) begin
                cursor <= (cursor == LAST) ? '0 : cursor + 1'b1;
            end
        end
    end

    always_comb begin
        copy_en = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_COPY: begin copy_en = 1'b1; busy = 1'b1; end
            ST_WALK: begin step_en = !at_stop; busy = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (busy && state == ST_COPY));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r8_cursor_advance: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cursor == (($past(cursor) == LAST) ? '0 : $past(cursor) + 1'b1)));
endmodule

// File: rtl/rr_table.sv
module rr_table #(
    parameter int NUM_ARCH = 16,
    parameter int TAG_W    = 6,
    localparam int MAP_N   = NUM_ARCH + 1,
    localparam int ARCH_W  = $clog2(NUM_ARCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cp_en,
    input  logic [MAP_N*TAG_W-1:0] cp_map,
    input  logic                   wr_reg_we,
    input  logic [ARCH_W-1:0]      wr_reg_arch,
    input  logic [TAG_W-1:0]       wr_reg_tag,
    input  logic                   wr_flag_we,
    input  logic [TAG_W-1:0]       wr_flag_tag,
    output logic [MAP_N*TAG_W-1:0] map_flat
);
    for (genvar i = 0; i < MAP_N; i++) begin : g_slot
        logic             hit;
        logic [TAG_W-1:0] wdata;
        if (i < NUM_ARCH) begin : g_reg
            assign hit   = wr_reg_we && (wr_reg_arch == ARCH_W'(i));
            assign wdata = wr_reg_tag;
        end else begin : g_flag
            assign hit   = wr_flag_we;
            assign wdata = wr_flag_tag;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                map_flat[i*TAG_W +: TAG_W] <= TAG_W'(i);
            else if (cp_en)
                map_flat[i*TAG_W +: TAG_W] <= cp_map[i*TAG_W +: TAG_W];
            else if (hit)
                map_flat[i*TAG_W +: TAG_W] <= wdata;
        end
    end

    a_r3_copy_whole: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |=> (map_flat == $past(cp_map)));

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_en && !wr_reg_we && !wr_flag_we) |=> $stable(map_flat));
endmodule

// File: rtl/rat_rebuild.sv
module rat_rebuild #(
    parameter int NUM_ARCH  = 16,
    parameter int TAG_W     = 6,
    parameter int ROB_DEPTH = 16,
    localparam int MAP_N    = NUM_ARCH + 1,
    localparam int ARCH_W   = $clog2(NUM_ARCH),
    localparam int IDX_W    = $clog2(ROB_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [IDX_W-1:0]       start_idx,
    input  logic [IDX_W-1:0]       stop_idx,
    input  logic [MAP_N*TAG_W-1:0] cmt_map,
    output logic [IDX_W-1:0]       rob_rd_idx,
    input  logic                   rob_reg_we,
    input  logic [ARCH_W-1:0]      rob_reg_arch,
    input  logic [TAG_W-1:0]       rob_reg_tag,
    input  logic                   rob_flag_we,
    input  logic [TAG_W-1:0]       rob_flag_tag,
    input  logic                   ren_reg_we,
    input  logic [ARCH_W-1:0]      ren_reg_arch,
    input  logic [TAG_W-1:0]       ren_reg_tag,
    input  logic                   ren_flag_we,
    input  logic [TAG_W-1:0]       ren_flag_tag,
    output logic [MAP_N*TAG_W-1:0] spec_map,
    output logic                   busy,
    output logic                   done
);
    logic              copy_en, step_en;
    logic              wr_reg_we, wr_flag_we;
    logic [ARCH_W-1:0] wr_reg_arch;
    logic [TAG_W-1:0]  wr_reg_tag, wr_flag_tag;

    rr_walker #(.ROB_DEPTH(ROB_DEPTH)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_idx(start_idx),
        .stop_idx (stop_idx),
        .cursor   (rob_rd_idx),
        .copy_en  (copy_en),
        .step_en  (step_en),
        .busy     (busy),
        .done     (done)
    );

    // Replay owns the write port during the walk; rename owns it otherwise.
    always_comb begin
        if (step_en) begin
            wr_reg_we   = rob_reg_we;
            wr_reg_arch = rob_reg_arch;
            wr_reg_tag  = rob_reg_tag;
            wr_flag_we  = rob_flag_we;
            wr_flag_tag = rob_flag_tag;
        end else begin
            wr_reg_we   = ren_reg_we && !busy;
            wr_reg_arch = ren_reg_arch;
            wr_reg_tag  = ren_reg_tag;
            wr_flag_we  = ren_flag_we && !busy;
            wr_flag_tag = ren_flag_tag;
        end
    end

    rr_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .cp_en      (copy_en),
        .cp_map     (cmt_map),
        .wr_reg_we  (wr_reg_we),
        .wr_reg_arch(wr_reg_arch),
        .wr_reg_tag (wr_reg_tag),
        .wr_flag_we (wr_flag_we),
        .wr_flag_tag(wr_flag_tag),
        .map_flat   (spec_map)
    );

    a_r9_rename_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !copy_en && !step_en) |=> $stable(spec_map));

    a_r6_flag_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && rob_flag_we) |=> (spec_map[NUM_ARCH*TAG_W +: TAG_W] == $past(rob_flag_tag)));
endmodule

// File: tb/sim_rat_rebuild.sv
module sim_rat_rebuild;
    localparam int NA = 16, TW = 6, RD = 16, MN = 17, IW = 4, AW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start;
    logic [IW-1:0] start_idx, stop_idx, rob_rd_idx;
    logic [MN*TW-1:0] cmt_map, spec_map;
    logic          rob_reg_we, rob_flag_we, busy, done;
    logic [AW-1:0] rob_reg_arch, ren_reg_arch;
    logic [TW-1:0] rob_reg_tag, rob_flag_tag, ren_reg_tag, ren_flag_tag;
    logic          ren_reg_we, ren_flag_we;

    logic          b_rwe [RD];
    logic [AW-1:0] b_rarch [RD];
    logic [TW-1:0] b_rtag [RD];
    logic          b_fwe [RD];
    logic [TW-1:0] b_ftag [RD];
    logic [TW-1:0] exp_map [MN];

    assign rob_reg_we   = b_rwe[rob_rd_idx];
    assign rob_reg_arch = b_rarch[rob_rd_idx];
    assign rob_reg_tag  = b_rtag[rob_rd_idx];
    assign rob_flag_we  = b_fwe[rob_rd_idx];
    assign rob_flag_tag = b_ftag[rob_rd_idx];

    rat_rebuild u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
        .stop_idx(stop_idx), .cmt_map(cmt_map), .rob_rd_idx(rob_rd_idx),
        .rob_reg_we(rob_reg_we), .rob_reg_arch(rob_reg_arch),
        .rob_reg_tag(rob_reg_tag), .rob_flag_we(rob_flag_we),
        .rob_flag_tag(rob_flag_tag), .ren_reg_we(ren_reg_we),
        .ren_reg_arch(ren_reg_arch), .ren_reg_tag(ren_reg_tag),
        .ren_flag_we(ren_flag_we), .ren_flag_tag(ren_flag_tag),
        .spec_map(spec_map), .busy(busy), .done(done)
    );

    int total = 0, bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [MN*TW-1:0] pack_exp();
        logic [MN*TW-1:0] v = '0;
        for (int i = 0; i < MN; i++) v[i*TW +: TW] = exp_map[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode 0 mixed, 1 no writes, 2 reg only, 3 flags only, 4 all to slot 7
    task automatic fill(input int mode);
        for (int i = 0; i < MN; i++) begin
            seed = nxt(seed);
            cmt_map[i*TW +: TW] = seed[TW-1:0];
        end
        for (int i = 0; i < RD; i++) begin
            seed = nxt(seed);
            b_rarch[i] = seed[3:0];
            b_rtag[i]  = seed[9:4];
            b_ftag[i]  = seed[15:10];
            b_rwe[i]   = seed[16] | seed[17];
            b_fwe[i]   = seed[18];
            if (mode == 1) begin b_rwe[i] = 1'b0; b_fwe[i] = 1'b0; end
            if (mode == 2) begin b_rwe[i] = 1'b1; b_fwe[i] = 1'b0; end
            if (mode == 3) begin b_rwe[i] = 1'b0; b_fwe[i] = 1'b1; end
            if (mode == 4) begin b_rwe[i] = 1'b1; b_rarch[i] = 4'd7; end
        end
    endtask

    task automatic run(input int s, input int n, input bit poke, input string tag);
        int c;
        for (int i = 0; i < MN; i++) exp_map[i] = cmt_map[i*TW +: TW];
        for (int k = 0; k < n; k++) begin
            int ix = (s + k) % RD;
            if (b_rwe[ix]) exp_map[b_rarch[ix]] = b_rtag[ix];
            if (b_fwe[ix]) exp_map[NA] = b_ftag[ix];
        end
        @(negedge clk);
        start = 1'b1;
        start_idx = IW'(s);
        stop_idx = IW'((s + n) % RD);
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (busy && c < 40) begin
            chk(!done, "R2 done during busy", 128'(done), 128'(0));
            if (c >= 1 && c <= n)
                chk(rob_rd_idx == IW'((s + c - 1) % RD), "R8 read index",
                    128'(rob_rd_idx), 128'((s + c - 1) % RD));
            if (poke) begin
                seed = nxt(seed);
                ren_reg_we = 1'b1; ren_reg_arch = seed[3:0]; ren_reg_tag = seed[9:4];
                ren_flag_we = 1'b1; ren_flag_tag = seed[15:10];
                start = 1'b1; stop_idx = IW'((s + 1) % RD);
            end
            c++;
            @(negedge clk);
        end
        ren_reg_we = 1'b0; ren_flag_we = 1'b0; start = 1'b0;
        chk(c == n + 2, "R7 busy length", 128'(c), 128'(n + 2));
        chk(done == 1'b1, "R7 done raised", 128'(done), 128'(1));
        chk(spec_map == pack_exp(), poke ? {tag, " R9 under rename/start"} : tag,
            128'(spec_map), 128'(pack_exp()));
        chk(spec_map[NA*TW +: TW] == exp_map[NA], "R6 flags slot",
            128'(spec_map[NA*TW +: TW]), 128'(exp_map[NA]));
        @(negedge clk);
        chk(!done && !busy, "R7 done one cycle", 128'({busy, done}), 128'(0));
        if (poke)
            chk(spec_map == pack_exp(), "R2 late start ignored",
                128'(spec_map), 128'(pack_exp()));
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; start_idx = '0; stop_idx = '0; cmt_map = '0;
        ren_reg_we = 1'b0; ren_reg_arch = '0; ren_reg_tag = '0;
        ren_flag_we = 1'b0; ren_flag_tag = '0;
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < MN; i++) exp_map[i] = TW'(i);
        chk(spec_map == pack_exp(), "R1 identity map", 128'(spec_map), 128'(pack_exp()));
        chk(!busy && !done, "R1 idle flags", 128'({busy, done}), 128'(0));

        for (int s = 0; s < RD; s++) begin
            for (int j = 0; j < 5; j++) begin
                int n;
                n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 7 : 15;
                fill(0);
                run(s, n, (s % 3) == 0, (n == 0) ? "R10 empty walk" : "R4 R3 replay");
            end
        end

        fill(1); run(5, 9, 1'b0, "R5 no-dest entries");
        fill(2); run(12, 10, 1'b0, "R5 reg-only entries");
        fill(3); run(9, 11, 1'b0, "R6 flag-only entries");
        fill(4); run(14, 6, 1'b0, "R4 later entry wins");

        @(negedge clk);
        ren_reg_we = 1'b1; ren_reg_arch = 4'd3; ren_reg_tag = 6'h2a;
        ren_flag_we = 1'b1; ren_flag_tag = 6'h15;
        @(negedge clk);
        ren_reg_we = 1'b0; ren_flag_we = 1'b0;
        chk(spec_map[3*TW +: TW] == 6'h2a, "R9 rename reg applies",
            128'(spec_map[3*TW +: TW]), 128'(6'h2a));
        chk(spec_map[NA*TW +: TW] == 6'h15, "R9 rename flags applies",
            128'(spec_map[NA*TW +: TW]), 128'(6'h15));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule